// File: doc/BRIEF.md
# Shared-Storage Multi-Queue Flit Buffer

This block is the flit store at one input port of an on-chip router. A single storage array of `DEPTH` slots is shared among `NQ` logical queues, one for each output port. No slot belongs to a fixed queue. Each queue is a singly linked chain of slots with its own head and tail pointer. Every unused slot sits on one free chain.

A flit is written together with the index of its destination output. The block takes the first slot from the free chain, stores the flit there and appends the slot to that destination's chain. On the read side, downstream logic names a queue. The block always shows the oldest flit of that queue on `rd_data`, and asserting `rd_en` removes it. The removed slot goes back onto the free chain. Any non-empty queue can be drained at any time, so a stalled output never holds up flits bound for other outputs. One flag per queue reports that the queue is empty. A single flag reports that no slot is free.

Top module: `dmq_buffer`

## Requirements
- R1: After reset every bit of `q_empty` is 1 and `full` is 0.
- R2: A write with `wr_en`=1 while `full`=0 adds `wr_data` to the queue numbered `wr_qid`. From the next cycle, `q_empty[wr_qid]` is 0.
- R3: Each queue gives back its flits in the order they were written. While `q_empty[rd_qid]`=0, `rd_data` combinationally shows the oldest flit of queue `rd_qid`, and `rd_en`=1 removes it at the clock edge.
- R4: A flit can be removed from any non-empty queue whatever the state of the other queues, and their contents are not affected.
- R5: One queue alone can hold all `DEPTH` flits.
- R6: `full` is 1 exactly when `DEPTH` flits are stored. A write while `full`=1 is dropped and changes no queue.
- R7: `rd_en` naming a queue with `q_empty` set changes nothing.
- R8: A write and a removal in the same cycle both take effect. This also holds when both target one queue that holds a single flit. A write in a cycle that starts with `full`=1 is still dropped, even if a removal happens in that cycle.
- R9: `q_empty[q]` returns to 1 when the last flit of queue q leaves. Slots freed by removals are reused, so traffic can go on without limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write a flit this cycle |
| wr_qid | input | $clog2(NQ) | Destination queue of the written flit |
| wr_data | input | DATA_W | Flit to write |
| rd_en | input | 1 | Remove the head flit of queue `rd_qid` |
| rd_qid | input | $clog2(NQ) | Queue being read |
| rd_data | output | DATA_W | Head flit of queue `rd_qid` (valid when that queue is non-empty) |
| q_empty | output | NQ | One bit per queue, 1 when that queue holds no flit |
| full | output | 1 | 1 when every slot is in use |

## Verification
The assertions assume that `wr_qid` and `rd_qid` always name an existing queue. They also assume that the control inputs are defined on every clock edge after reset. The properties track an occupancy count rebuilt from the accepted writes and removals seen at the ports.

The stimulus keeps within these assumptions. Every queue index is drawn from the range 0 to NQ-1, and every input is driven to a known value before reset is released. Removals from empty queues and writes while full are issued on purpose, because the block must tolerate them.

// File: rtl/dmq_buffer.sv
module dmq_buffer #(
  parameter int DATA_W = 16,
  parameter int NQ     = 4,
  parameter int DEPTH  = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [$clog2(NQ)-1:0] wr_qid,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic                  rd_en,
  input  logic [$clog2(NQ)-1:0] rd_qid,
  output logic [DATA_W-1:0]     rd_data,
  output logic [NQ-1:0]         q_empty,
  output logic                  full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem  [DEPTH];
  logic [AW-1:0]     nxt  [DEPTH];
  logic [AW-1:0]     head [NQ];
  logic [AW-1:0]     tail [NQ];
  logic [NQ-1:0]     empty_q;
  logic [AW-1:0]     fhead, ftail;
  logic [CW-1:0]     fcnt;

  logic          enq, deq, same_q, deq_last;
  logic [AW-1:0] nslot, oslot;

  assign full     = (fcnt == '0);
  assign q_empty  = empty_q;
  assign enq      = wr_en && !full;
  assign deq      = rd_en && !empty_q[rd_qid];
  assign nslot    = fhead;
  assign oslot    = head[rd_qid];
  assign same_q   = enq && deq && (wr_qid == rd_qid);
  assign deq_last = (head[rd_qid] == tail[rd_qid]);
  assign rd_data  = mem[oslot];

  always_ff @(posedge clk)
    if (enq) mem[nslot] <= wr_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) nxt[i] <= AW'(i + 1);
      for (int q = 0; q < NQ; q++) begin
        head[q] <= '0;
        tail[q] <= '0;
      end
      empty_q <= '1;
      fhead   <= '0;
      ftail   <= AW'(DEPTH - 1);
      fcnt    <= CW'(DEPTH);
    end else begin
      if (deq) begin
        if (deq_last) empty_q[rd_qid] <= 1'b1;
        else          head[rd_qid]    <= nxt[oslot];
      end
      if (enq) begin
        if (empty_q[wr_qid] || (same_q && deq_last)) begin
          head[wr_qid]    <= nslot;
          empty_q[wr_qid] <= 1'b0;
        end else begin
          nxt[tail[wr_qid]] <= nslot;
        end
        tail[wr_qid] <= nslot;
      end
      if (enq && !deq) begin
        fhead <= nxt[fhead];
        fcnt  <= fcnt - 1'b1;
      end else if (deq && !enq) begin
        if (fcnt == '0) fhead <= oslot;
        else            nxt[ftail] <= oslot;
        ftail <= oslot;
        fcnt  <= fcnt + 1'b1;
      end else if (enq && deq) begin
        if (fcnt == CW'(1)) begin
          fhead <= oslot;
        end else begin
          fhead      <= nxt[fhead];
          nxt[ftail] <= oslot;
        end
        ftail <= oslot;
      end
    end
  end
endmodule

// File: rtl/dmq_buffer_chk.sv
module dmq_buffer_chk #(
  parameter int DATA_W = 16,
  parameter int NQ     = 4,
  parameter int DEPTH  = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  wr_en,
  input logic [$clog2(NQ)-1:0] wr_qid,
  input logic [DATA_W-1:0]     wr_data,
  input logic                  rd_en,
  input logic [$clog2(NQ)-1:0] rd_qid,
  input logic [DATA_W-1:0]     rd_data,
  input logic [NQ-1:0]         q_empty,
  input logic                  full
);
  localparam int CW = $clog2(DEPTH + 1);
  logic [CW-1:0] occ;
  logic acc_w, acc_r;
  assign acc_w = wr_en && !full;
  assign acc_r = rd_en && !q_empty[rd_qid];

  always_ff @(posedge clk)
    if (!rst_n) occ <= '0;
    else if (acc_w && !acc_r) occ <= occ + 1'b1;
    else if (acc_r && !acc_w) occ <= occ - 1'b1;

  a_r6_full_tracks_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    full == (occ == CW'(DEPTH)));
  a_r6_full_holds_without_removal: assert property (@(posedge clk) disable iff (!rst_n)
    full && !acc_r |=> full);
  a_r2_write_fills_queue: assert property (@(posedge clk) disable iff (!rst_n)
    acc_w |=> !q_empty[$past(wr_qid)]);
  a_r7_idle_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_w && !acc_r |=> $stable(q_empty));
  a_r1_empty_when_unoccupied: assert property (@(posedge clk) disable iff (!rst_n)
    occ == '0 |-> (&q_empty) && !full);
  a_r9_flags_within_occupancy: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~q_empty) <= int'(occ));
endmodule

bind dmq_buffer dmq_buffer_chk #(.DATA_W(DATA_W), .NQ(NQ), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_dmq_buffer.sv
module tb_dmq_buffer;
  localparam int DW = 16, NQ = 4, DEPTH = 16;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, rd_en = 0;
  logic [1:0] wr_qid = 0, rd_qid = 0;
  logic [DW-1:0] wr_data = 0;
  logic [DW-1:0] rd_data;
  logic [NQ-1:0] q_empty;
  logic full;

  dmq_buffer #(.DATA_W(DW), .NQ(NQ), .DEPTH(DEPTH)) dut (.*);

  always #4 clk = ~clk;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [DW-1:0] model [NQ][$];

  function automatic int stored();
    int s = 0;
    for (int q = 0; q < NQ; q++) s += model[q].size();
    return s;
  endfunction

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // monitor: compare flags and head flit against the scoreboard, then commit
  task automatic step(bit we, int wq, logic [DW-1:0] wd, bit re, int rq, string tag);
    bit acc_w, acc_r;
    @(negedge clk);
    wr_en = we; wr_qid = 2'(wq); wr_data = wd; rd_en = re; rd_qid = 2'(rq);
    #1;
    for (int q = 0; q < NQ; q++)
      chk(q_empty[q] == (model[q].size() == 0), tag, "q_empty", int'(q_empty[q]),
          int'(model[q].size() == 0));
    chk(full == (stored() == DEPTH), tag, "full", int'(full), int'(stored() == DEPTH));
    if (re && model[rq].size() > 0)
      chk(rd_data == model[rq][0], tag, "rd_data", int'(rd_data), int'(model[rq][0]));
    acc_w = we && stored() < DEPTH;
    acc_r = re && model[rq].size() > 0;
    @(posedge clk);
    if (acc_r) void'(model[rq].pop_front());
    if (acc_w) model[wq].push_back(wd);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1;
    // R1: reset state
    step(0, 0, 0, 0, 0, "R1");
    // R2: writes to several queues, interleaved
    step(1, 0, 16'h1000, 0, 0, "R2");
    step(1, 2, 16'h2000, 0, 0, "R2");
    step(1, 0, 16'h1001, 0, 0, "R2");
    step(1, 3, 16'h3000, 0, 0, "R2");
    step(1, 2, 16'h2001, 0, 0, "R2");
    // R4: drain queue 2 while queue 0 and 3 hold
    step(0, 0, 0, 1, 2, "R4");
    step(0, 0, 0, 1, 2, "R4");
    // R3: order within queue 0, R9: flags clear on last flit
    step(0, 0, 0, 1, 0, "R3");
    step(0, 0, 0, 1, 0, "R9");
    step(0, 0, 0, 1, 3, "R9");
    // R7: removals from empty queues change nothing
    step(1, 1, 16'h4000, 0, 0, "R7");
    step(0, 0, 0, 1, 2, "R7");
    step(0, 0, 0, 1, 0, "R7");
    // R8: write and removal on one queue holding one flit
    step(1, 1, 16'h4001, 1, 1, "R8");
    step(1, 1, 16'h4002, 1, 1, "R8");
    step(0, 0, 0, 1, 1, "R8");
    step(0, 0, 0, 0, 0, "R8");
    // R5/R6: one queue takes every slot, then a write while full
    for (int i = 0; i < DEPTH; i++) step(1, 0, 16'h5000 + 16'(i), 0, 0, "R5");
    step(1, 3, 16'hDEAD, 0, 0, "R6");
    step(0, 0, 0, 0, 0, "R6");
    // R8: while full, removal plus write: write dropped
    step(1, 3, 16'hBEEF, 1, 0, "R8");
    step(1, 3, 16'h6000, 1, 0, "R8");
    for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, 0, "R3");
    for (int i = 0; i < 2; i++) step(0, 0, 0, 1, 3, "R6");
    step(0, 0, 0, 0, 0, "R6");
    // R9: long mixed traffic reuses freed slots
    for (int i = 0; i < 4000; i++)
      step(($urandom % 3) != 0, int'($urandom % NQ), 16'($urandom),
           ($urandom % 2) != 0, int'($urandom % NQ), "R9");
    for (int q = 0; q < NQ; q++)
      for (int i = 0; i < DEPTH; i++) step(0, 0, 0, 1, q, "R9");
    step(0, 0, 0, 0, 0, "R9");
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule